// File: doc/BRIEF.md
# Parallel Window Access Pixel Memory

This block stores a two-dimensional image of `IMG_W` columns by `IMG_H` rows and hands back a full rectangular window of `WIN_W` by `WIN_H` pixels in one access. The requester gives only the top-left coordinate of the window. The pixels are spread over `WIN_W*WIN_H` banks so that no window ever needs two pixels from the same bank. A pixel at (x, y) lives in bank (x mod `WIN_W`, y mod `WIN_H`), at the word whose row part is y div `WIN_H` and whose column part is x div `WIN_W`.

Address generation is shared. One row selector serves each horizontal group of banks. It turns the window's y origin into `WIN_H` adjacent row addresses, each either the base row or the next one. One column selector serves each vertical group of banks and picks either the base column or the next one. The raw bank outputs are then rotated by the origin's residues, so the window leaves in raster order with element [0][0] at the requested origin. The result is registered.

A single write port loads one pixel per cycle and is used to fill the image.

Top module: `win_pixel_mem`

## Requirements
- R1: While reset is held, and after it is released with no request, `rd_valid` and `rd_err` are 0 and `rd_win` is all zeros.
- R2: A write with `wr_en` high stores `wr_pix` at (`wr_x`, `wr_y`). Any later window that covers that position returns the stored value.
- R3: For an in-range request at (x0, y0), `rd_win` one cycle later holds pixel (x0+c, y0+r) at bits [(r*`WIN_W`+c)*`PIX_W` +: `PIX_W`], for r < `WIN_H` and c < `WIN_W`.
- R4: R3 holds for every combination of origin residues (x0 mod `WIN_W`, y0 mod `WIN_H`), so a window may start at any pixel.
- R5: `rd_valid` is high exactly in the cycle after a cycle with `rd_req` high. A new request can be made in every cycle with no gaps.
- R6: A request with x0 > `IMG_W`-`WIN_W` or y0 > `IMG_H`-`WIN_H` gives `rd_err` = 1 and an all-zero `rd_win` in the response cycle.
- R7: Origins on the last legal column and row (x0 = `IMG_W`-`WIN_W`, y0 = `IMG_H`-`WIN_H`) are accepted with `rd_err` = 0 and correct data.
- R8: When a read and a write in the same cycle touch the same pixel, the read returns the value that was there before the write.
- R9: While `rd_req` is low, `rd_win` keeps its previous value.

Ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write one pixel this cycle |
| wr_x | input | XW | Write column |
| wr_y | input | YW | Write row |
| wr_pix | input | PIX_W | Write data |
| rd_req | input | 1 | Window read request |
| rd_x | input | XW | Window origin column |
| rd_y | input | YW | Window origin row |
| rd_valid | output | 1 | Response present this cycle |
| rd_err | output | 1 | Requested origin was out of range |
| rd_win | output | WIN_W*WIN_H*PIX_W | Window pixels in raster order |

## Verification
On every cycle, the assertions check the response timing and the flags. Each request must produce `rd_valid` in the next cycle, and a cycle with no request must produce no response. Out-of-range origins must raise the error flag with zeroed data, and in-range origins must not. The window must hold still while no request is made. Whether the pixel contents are right can only be shown by the bench's scenarios, which compare against a reference image. This covers the rotation for every residue pair, the edge origins, and a read and write to the same pixel in one cycle.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  // width needed to hold values 0 .. v-1, never below one bit
  function automatic int unsigned cw(input int unsigned v);
    return (v > 1) ? $clog2(v) : 1;
  endfunction
endpackage

// File: rtl/pwm_axis_sel.sv
// Shared address selector for one axis: from the window origin, produce the
// per-lane word address (base or base+1) and the origin residue.
module pwm_axis_sel #(
  parameter int unsigned LANES = 3,
  parameter int unsigned OW    = 4,
  parameter int unsigned AW    = 3
) (
  input  logic [OW-1:0]             origin,
  output logic [LANES-1:0][AW-1:0]  lane_addr,
  output logic [OW-1:0]             phase
);
  logic [OW-1:0] base;

  always_comb begin
    base  = origin / OW'(LANES);
    phase = origin % OW'(LANES);
    for (int i = 0; i < LANES; i++) begin
      lane_addr[i] = AW'(base) + ((OW'(i) < phase) ? AW'(1) : AW'(0));
    end
  end
endmodule

// File: rtl/pwm_bank.sv
// One pixel bank: one synchronous write port, one combinational read port.
module pwm_bank #(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned DEPTH = 36,
  parameter int unsigned AW    = 7
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [PIX_W-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [PIX_W-1:0] rd_data
);
  localparam int unsigned IW = pwm_pkg::cw(DEPTH);

  logic [PIX_W-1:0] mem [DEPTH];
  logic             wr_ok;
  logic             rd_ok;

  always_comb begin
    wr_ok   = wr_en && (int'(wr_addr) < int'(DEPTH));
    rd_ok   = int'(rd_addr) < int'(DEPTH);
    rd_data = rd_ok ? mem[rd_addr[IW-1:0]] : '0;
  end

  always_ff @(posedge clk) begin
    if (wr_ok) begin
      mem[wr_addr[IW-1:0]] <= wr_data;
    end
  end
endmodule

// File: rtl/pwm_rotate.sv
// Reorders bank outputs (indexed by bank row/column) into window raster order.
module pwm_rotate #(
  parameter int unsigned M  = 3,
  parameter int unsigned N  = 2,
  parameter int unsigned P  = 8,
  parameter int unsigned XW = 4,
  parameter int unsigned YW = 4
) (
  input  logic [N-1:0][M-1:0][P-1:0] bank_pix,
  input  logic [XW-1:0]              xph,
  input  logic [YW-1:0]              yph,
  output logic [N-1:0][M-1:0][P-1:0] win_pix
);
  always_comb begin
    for (int r = 0; r < N; r++) begin
      for (int c = 0; c < M; c++) begin
        win_pix[r][c] = bank_pix[(int'(yph) + r) % N][(int'(xph) + c) % M];
      end
    end
  end
endmodule

// File: rtl/win_pixel_mem.sv
module win_pixel_mem #(
  parameter int unsigned IMG_W = 16,
  parameter int unsigned IMG_H = 12,
  parameter int unsigned WIN_W = 3,
  parameter int unsigned WIN_H = 2,
  parameter int unsigned PIX_W = 8,
  parameter int unsigned XW    = pwm_pkg::cw(IMG_W),
  parameter int unsigned YW    = pwm_pkg::cw(IMG_H)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [XW-1:0]                  wr_x,
  input  logic [YW-1:0]                  wr_y,
  input  logic [PIX_W-1:0]               wr_pix,
  input  logic                           rd_req,
  input  logic [XW-1:0]                  rd_x,
  input  logic [YW-1:0]                  rd_y,
  output logic                           rd_valid,
  output logic                           rd_err,
  output logic [WIN_W*WIN_H*PIX_W-1:0]   rd_win
);
  localparam int unsigned BC    = (IMG_W + WIN_W - 1) / WIN_W;
  localparam int unsigned BR    = (IMG_H + WIN_H - 1) / WIN_H;
  localparam int unsigned DEPTH = BC * BR;
  localparam int unsigned CAW   = pwm_pkg::cw(BC + 1);
  localparam int unsigned RAW   = pwm_pkg::cw(BR + 1);
  localparam int unsigned BAW   = pwm_pkg::cw((BR + 1) * BC + 1);

  typedef logic [WIN_H-1:0][WIN_W-1:0][PIX_W-1:0] win_t;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_s1, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  // shared address selection
  logic [WIN_H-1:0][RAW-1:0] row_addr;
  logic [WIN_W-1:0][CAW-1:0] col_addr;
  logic [YW-1:0]             yph;
  logic [XW-1:0]             xph;

  pwm_axis_sel #(.LANES(WIN_H), .OW(YW), .AW(RAW)) u_row_sel (
    .origin(rd_y), .lane_addr(row_addr), .phase(yph)
  );
  pwm_axis_sel #(.LANES(WIN_W), .OW(XW), .AW(CAW)) u_col_sel (
    .origin(rd_x), .lane_addr(col_addr), .phase(xph)
  );

  // write address split
  logic [XW-1:0] wr_col, wr_bx;
  logic [YW-1:0] wr_row, wr_by;
  logic          wr_in;
  always_comb begin
    wr_col = wr_x / XW'(WIN_W);
    wr_bx  = wr_x % XW'(WIN_W);
    wr_row = wr_y / YW'(WIN_H);
    wr_by  = wr_y % YW'(WIN_H);
    wr_in  = (int'(wr_x) < int'(IMG_W)) && (int'(wr_y) < int'(IMG_H));
  end

  logic [BAW-1:0] wr_addr;
  assign wr_addr = BAW'(wr_row) * BAW'(BC) + BAW'(wr_col);

  // bank array
  win_t bank_pix;
  for (genvar by = 0; by < WIN_H; by++) begin : g_brow
    for (genvar bx = 0; bx < WIN_W; bx++) begin : g_bcol
      logic           b_we;
      logic [BAW-1:0] b_raddr;
      assign b_we    = wr_en && wr_in && (wr_bx == XW'(bx)) && (wr_by == YW'(by));
      assign b_raddr = BAW'(row_addr[by]) * BAW'(BC) + BAW'(col_addr[bx]);
      pwm_bank #(.PIX_W(PIX_W), .DEPTH(DEPTH), .AW(BAW)) u_bank (
        .clk    (clk),
        .wr_en  (b_we),
        .wr_addr(wr_addr),
        .wr_data(wr_pix),
        .rd_addr(b_raddr),
        .rd_data(bank_pix[by][bx])
      );
    end
  end

  win_t win_rot;
  pwm_rotate #(.M(WIN_W), .N(WIN_H), .P(PIX_W), .XW(XW), .YW(YW)) u_rotate (
    .bank_pix(bank_pix), .xph(xph), .yph(yph), .win_pix(win_rot)
  );

  // response register: next state
  logic oob;
  logic valid_d, err_d, valid_q, err_q;
  win_t win_d, win_q;

  always_comb begin
    oob     = (int'(rd_x) > int'(IMG_W - WIN_W)) || (int'(rd_y) > int'(IMG_H - WIN_H));
    valid_d = rd_req;
    err_d   = rd_req && oob;
    win_d   = win_q;
    if (rd_req) begin
      win_d = oob ? '0 : win_rot;
    end
  end

  // response register: state
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      win_q   <= '0;
    end else begin
      valid_q <= valid_d;
      err_q   <= err_d;
      if (rd_req) begin
        win_q <= win_d;
      end
    end
  end

  assign rd_valid = valid_q;
  assign rd_err   = err_q;
  assign rd_win   = win_q;
endmodule

// File: rtl/pwm_checker.sv
module pwm_checker #(
  parameter int unsigned IMG_W = 16,
  parameter int unsigned IMG_H = 12,
  parameter int unsigned WIN_W = 3,
  parameter int unsigned WIN_H = 2,
  parameter int unsigned PIX_W = 8,
  parameter int unsigned XW    = 4,
  parameter int unsigned YW    = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         rd_req,
  input logic [XW-1:0]                rd_x,
  input logic [YW-1:0]                rd_y,
  input logic                         rd_valid,
  input logic                         rd_err,
  input logic [WIN_W*WIN_H*PIX_W-1:0] rd_win
);
  logic req_oob;
  assign req_oob = (int'(rd_x) > int'(IMG_W - WIN_W)) || (int'(rd_y) > int'(IMG_H - WIN_H));

  // R5
  req_gives_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);
  // R5
  idle_gives_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);
  // R6
  oob_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && req_oob) |=> rd_err);
  // R7
  inrange_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !req_oob) |=> !rd_err);
  // R6
  err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> (rd_valid && rd_win == '0));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> $stable(rd_win));
endmodule

bind win_pixel_mem pwm_checker #(
  .IMG_W(IMG_W), .IMG_H(IMG_H), .WIN_W(WIN_W), .WIN_H(WIN_H),
  .PIX_W(PIX_W), .XW(XW), .YW(YW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_x(rd_x), .rd_y(rd_y),
  .rd_valid(rd_valid), .rd_err(rd_err), .rd_win(rd_win)
);

// File: tb/win_pixel_mem_tb_top.sv
module win_pixel_mem_tb_top;
  localparam int K  = 16;
  localparam int L  = 12;
  localparam int M  = 3;
  localparam int N  = 2;
  localparam int P  = 8;
  localparam int XW = 4;
  localparam int YW = 4;
  localparam int WV = M * N * P;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [XW-1:0] wr_x;
  logic [YW-1:0] wr_y;
  logic [P-1:0]  wr_pix;
  logic          rd_req;
  logic [XW-1:0] rd_x;
  logic [YW-1:0] rd_y;
  logic          rd_valid;
  logic          rd_err;
  logic [WV-1:0] rd_win;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;
  logic [P-1:0]  img [K][L];
  logic [WV-1:0] last_win;

  always #5 clk = ~clk;

  win_pixel_mem #(.IMG_W(K), .IMG_H(L), .WIN_W(M), .WIN_H(N), .PIX_W(P)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_x(wr_x), .wr_y(wr_y),
    .wr_pix(wr_pix), .rd_req(rd_req), .rd_x(rd_x), .rd_y(rd_y),
    .rd_valid(rd_valid), .rd_err(rd_err), .rd_win(rd_win)
  );

  function automatic logic [WV-1:0] win_of(input int x, input int y);
    logic [WV-1:0] w = '0;
    for (int r = 0; r < N; r++)
      for (int c = 0; c < M; c++)
        w[(r*M+c)*P +: P] = img[x+c][y+r];
    return w;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [WV-1:0] act,
                       input logic [WV-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive one cycle (called just after a falling edge), check the response
  task automatic step(input bit req, input int x, input int y, input bit we,
                      input int wx, input int wy, input logic [P-1:0] wp,
                      input string tag);
    logic [WV-1:0] exp_w;
    bit exp_err;
    rd_req = req; rd_x = XW'(x); rd_y = YW'(y);
    wr_en = we; wr_x = XW'(wx); wr_y = YW'(wy); wr_pix = wp;
    exp_err = req && (x > K - M || y > L - N);
    if (!req)         exp_w = last_win;
    else if (exp_err) exp_w = '0;
    else              exp_w = win_of(x, y);
    @(negedge clk);
    if (we && wx < K && wy < L) img[wx][wy] = wp;
    check(rd_valid == req, "R5 valid", WV'(rd_valid), WV'(req));
    check(rd_err == exp_err, exp_err ? "R6 err" : "R7 err", WV'(rd_err), WV'(exp_err));
    check(rd_win === exp_w, req ? tag : "R9 hold", rd_win, exp_w);
    last_win = exp_w;
  endtask

  task automatic print_summary;
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete");
    print_summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    rst_n = 1'b0; wr_en = 0; wr_x = '0; wr_y = '0; wr_pix = '0;
    rd_req = 0; rd_x = '0; rd_y = '0;
    last_win = '0;
    repeat (3) @(negedge clk);
    // R1: state while in reset
    check(!rd_valid && !rd_err && rd_win == '0, "R1 in reset",
          {rd_valid, rd_err, rd_win[WV-3:0]}, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: state after release
    check(!rd_valid && !rd_err && rd_win == '0, "R1 after release",
          {rd_valid, rd_err, rd_win[WV-3:0]}, '0);

    // R2: fill the image
    for (int y = 0; y < L; y++)
      for (int x = 0; x < K; x++)
        step(0, 0, 0, 1, x, y, P'($urandom), "R2");

    // R3 basic windows
    step(1, 0, 0, 0, 0, 0, 0, "R3 origin");
    step(1, 5, 4, 0, 0, 0, 0, "R3 mid");
    // R4 every residue pair, back to back (R5)
    for (int yr = 0; yr < N; yr++)
      for (int xr = 0; xr < M; xr++)
        step(1, 6 + xr, 2 + yr, 0, 0, 0, 0, "R4 residue");
    // R7 edges
    step(1, K - M, L - N, 0, 0, 0, 0, "R7 corner");
    step(1, K - M, 0, 0, 0, 0, 0, "R7 right edge");
    step(1, 0, L - N, 0, 0, 0, 0, "R7 bottom edge");
    // R6 out of range
    step(1, K - M + 1, 0, 0, 0, 0, 0, "R6 x over");
    step(1, 0, L - N + 1, 0, 0, 0, 0, "R6 y over");
    step(1, 15, 15, 0, 0, 0, 0, "R6 both over");
    // R9 hold while idle
    step(1, 4, 3, 0, 0, 0, 0, "R3 before idle");
    step(0, 9, 9, 0, 0, 0, 0, "R9");
    step(0, 1, 1, 0, 0, 0, 0, "R9");
    // R8 read and write same pixel in one cycle
    step(1, 4, 5, 1, 4, 5, 8'hC3 ^ img[4][5], "R8 old value");
    step(1, 4, 5, 0, 0, 0, 0, "R2 new value");
    step(1, 3, 4, 1, 5, 5, 8'h3C ^ img[5][5], "R8 old value inner");
    step(1, 3, 4, 0, 0, 0, 0, "R2 new value inner");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      step($urandom_range(0, 3) != 0, $urandom_range(0, 15), $urandom_range(0, 15),
           $urandom_range(0, 1) == 1, $urandom_range(0, K - 1), $urandom_range(0, L - 1),
           P'($urandom), "R3 random");
    end

    rd_req = 0; wr_en = 0;
    @(negedge clk);
    print_summary();
    $finish;
  end
endmodule